// File: doc/BRIEF.md
# E3 Frame Alignment Maintenance Monitor

This block watches a byte-wide E3 receive stream after the frame search logic has locked onto the frame boundary. Every frame has a fixed length. The first two octets of each frame must carry the alignment pattern 0xF6 then 0x28, and the block checks that pattern in every frame. A single bad frame, or a short run of them, is tolerated. Each bad frame is still recorded in a saturating event counter. Four bad frames in a row drop the block into out-of-frame. If the frame search logic does not re-align within a programmable number of frames, the block goes on to loss-of-frame.

The alarm outputs are active high. A small read port gives access to four registers: the clear-on-read change-of-state interrupt bits, a live status byte, and the error counter split into a high byte and a low byte. Reading the high byte freezes the low byte and clears the counter, so a read of the high byte followed by a read of the low byte always returns one coherent value. A frame-start pulse from the search logic re-establishes alignment while the block is out of frame. The same pulse is ignored while the block is in frame.

Top module: `e3_fa_monitor`

## Requirements
- R1: After reset, oof_o and lof_o are 1, the interrupt register reads 0x00, the status register reads 0x60 (with ALGO_SEL=0), and the error counter is 0.
- R2: A frame is FRAME_LEN octets, counted only on cycles with byte_vld_i high. It is errored when octet 0 is not 0xF6 or octet 1 is not 0x28. The verdict is taken on octet 1, and payload octets are never checked.
- R3: While in frame, oof_o rises only on the 4th consecutive errored frame, at the clock edge that accepts octet 1 of that frame. A good frame restarts the run.
- R4: Each errored frame seen while in frame adds one to the error counter. Frames seen while out of frame or in loss-of-frame add nothing.
- R5: The error counter saturates at all ones (0x3FF for ERR_W=10, 0xFFFF by default) and does not wrap.
- R6: A read of address 2 returns the counter bits above bit 7, zero-extended. The same read copies the low 8 bits to a snapshot and clears the counter. A read of address 3 returns that snapshot.
- R7: While out of frame, lof_o rises at the LOF_FRAMES-th frame boundary (position counter wrap) after oof_o rose. lof_o is never 1 while oof_o is 0.
- R8: A frame_start_i pulse together with byte_vld_i while out of frame or in loss-of-frame makes that byte octet 0 and returns the block to in-frame. Both alarm outputs go low, and interrupt bits 3 and 2 are set.
- R9: On such a re-alignment, interrupt bit 4 (change of alignment) is also set when the byte was not at position 0 of the free-running frame count.
- R10: frame_start_i has no effect while in frame. The frame position is kept, and no interrupt bit is set.
- R11: The interrupt register (address 0) holds bit 4 for change of alignment, bit 3 for OOF change and bit 2 for LOF change. Bits 7:5, 1 and 0 read 0. Entering out-of-frame sets bit 3, and entering loss-of-frame sets bit 2. A read returns the bits and clears them at the same edge.
- R12: The status register (address 1) reads {ALGO_SEL, lof, oof, 5'b0}. Addresses 4 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Received octet |
| byte_vld_i | input | 1 | Qualifies byte_i |
| frame_start_i | input | 1 | Re-alignment hint from frame search, marks byte_i as octet 0 |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register address |
| rd_data_o | output | 8 | Read data, valid in the cycle of rd_en_i |
| oof_o | output | 1 | Out-of-frame alarm |
| lof_o | output | 1 | Loss-of-frame alarm |

## Verification
The bench sends three errored frames, each faulty in a different octet, followed by a good one, and checks that the alarm stays low. A design that counts bad frames in total rather than in a row would raise OOF at this point. The fourth consecutive error is checked at the byte where it takes effect, and the OOF frame boundaries are counted one by one, so an off-by-one in either threshold shows up. Re-alignment is driven at a position that is not zero to catch a missing change-of-alignment bit, and a frame-start pulse is sent while in frame to catch a design that re-aligns when it should not. The counter is driven past saturation, and it is read after errors that arrived while out of frame, which shows up a counter that wraps or that keeps counting when it should not.

// File: rtl/e3_fa_pkg.sv
package e3_fa_pkg;
  localparam logic [7:0] FA1_OCT = 8'hF6;
  localparam logic [7:0] FA2_OCT = 8'h28;

  localparam logic [2:0] ADDR_INT    = 3'd0;
  localparam logic [2:0] ADDR_STAT   = 3'd1;
  localparam logic [2:0] ADDR_ERR_HI = 3'd2;
  localparam logic [2:0] ADDR_ERR_LO = 3'd3;

  localparam int INT_COFA_B = 4;
  localparam int INT_OOF_B  = 3;
  localparam int INT_LOF_B  = 2;

  typedef enum logic [1:0] {
    ST_INF = 2'd0,
    ST_OOF = 2'd1,
    ST_LOF = 2'd2
  } fa_state_e;
endpackage

// File: rtl/e3_fa_align.sv
module e3_fa_align
  import e3_fa_pkg::*;
#(
  parameter int FRAME_LEN = 537
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       vld_i,
  input  logic       realign_i,
  output logic       check_o,
  output logic       bad_o,
  output logic       frame_end_o,
  output logic       at_start_o
);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

  logic [POS_W-1:0] pos_q;
  logic             fa1_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      fa1_ok_q <= 1'b0;
    end else if (vld_i) begin
      if (realign_i)             pos_q <= POS_ONE;
      else if (pos_q == POS_LAST) pos_q <= '0;
      else                        pos_q <= pos_q + POS_ONE;
      // realigning byte is octet 0 of the new frame
      if (realign_i || pos_q == '0) fa1_ok_q <= (byte_i == FA1_OCT);
    end
  end

  assign check_o     = vld_i && !realign_i && (pos_q == POS_ONE);
  assign bad_o       = check_o && !(fa1_ok_q && (byte_i == FA2_OCT));
  assign frame_end_o = vld_i && !realign_i && (pos_q == POS_LAST);
  assign at_start_o  = (pos_q == '0);
endmodule

// File: rtl/e3_fa_state.sv
module e3_fa_state
  import e3_fa_pkg::*;
#(
  parameter int BAD_LIMIT  = 4,
  parameter int LOF_FRAMES = 24
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      check_i,
  input  logic      bad_i,
  input  logic      frame_end_i,
  output fa_state_e state_o,
  output logic      realign_o,
  output logic      oof_chg_o,
  output logic      lof_chg_o,
  output logic      err_o
);
  localparam int RUN_W = $clog2(BAD_LIMIT + 1);
  localparam int OFC_W = $clog2(LOF_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(BAD_LIMIT - 1);
  localparam logic [OFC_W-1:0] OFC_LAST = OFC_W'(LOF_FRAMES - 1);

  fa_state_e        state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [OFC_W-1:0] ofc_q, ofc_d;

  assign realign_o = start_i && (state_q != ST_INF);

  always_comb begin
    state_d   = state_q;
    run_d     = run_q;
    ofc_d     = ofc_q;
    oof_chg_o = 1'b0;
    lof_chg_o = 1'b0;
    case (state_q)
      ST_INF: begin
        if (check_i) begin
          if (!bad_i) begin
            run_d = '0;
          end else if (run_q == RUN_LAST) begin
            state_d   = ST_OOF;
            run_d     = '0;
            ofc_d     = '0;
            oof_chg_o = 1'b1;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
      end
      ST_OOF, ST_LOF: begin
        if (realign_o) begin
          state_d   = ST_INF;
          run_d     = '0;
          oof_chg_o = 1'b1;
          lof_chg_o = 1'b1;
        end else if (state_q == ST_OOF && frame_end_i) begin
          if (ofc_q == OFC_LAST) begin
            state_d   = ST_LOF;
            lof_chg_o = 1'b1;
          end else begin
            ofc_d = ofc_q + OFC_W'(1);
          end
        end
      end
      default: state_d = ST_LOF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOF;
      run_q   <= '0;
      ofc_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      ofc_q   <= ofc_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = (state_q == ST_INF) && bad_i;
endmodule

// File: rtl/e3_fa_regs.sv
module e3_fa_regs
  import e3_fa_pkg::*;
#(
  parameter int       ERR_W    = 16,
  parameter bit       ALGO_SEL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_addr_i,
  input  logic             oof_i,
  input  logic             lof_i,
  input  logic             set_oof_i,
  input  logic             set_lof_i,
  input  logic             set_cofa_i,
  input  logic             err_inc_i,
  output logic [7:0]       rd_data_o,
  output logic [4:0]       int_o,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             err_hi_rd_o
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic [4:0]       int_q, int_set;
  logic [ERR_W-1:0] cnt_q;
  logic [7:0]       snap_lo_q;
  logic [15:0]      cnt_ext;
  logic             rd_int;

  assign rd_int      = rd_en_i && (rd_addr_i == ADDR_INT);
  assign err_hi_rd_o = rd_en_i && (rd_addr_i == ADDR_ERR_HI);
  assign cnt_ext     = 16'(cnt_q);

  always_comb begin
    int_set             = '0;
    int_set[INT_COFA_B] = set_cofa_i;
    int_set[INT_OOF_B]  = set_oof_i;
    int_set[INT_LOF_B]  = set_lof_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q     <= '0;
      cnt_q     <= '0;
      snap_lo_q <= '0;
    end else begin
      // a new event wins over the clear of the same cycle
      int_q <= (rd_int ? 5'd0 : int_q) | int_set;
      if (err_hi_rd_o) begin
        snap_lo_q <= cnt_q[7:0];
        cnt_q     <= err_inc_i ? ERR_W'(1) : '0;
      end else if (err_inc_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + ERR_W'(1);
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (rd_en_i) begin
      case (rd_addr_i)
        ADDR_INT:    rd_data_o = {3'b000, int_q};
        ADDR_STAT:   rd_data_o = {ALGO_SEL, lof_i, oof_i, 5'b00000};
        ADDR_ERR_HI: rd_data_o = cnt_ext[15:8];
        ADDR_ERR_LO: rd_data_o = snap_lo_q;
        default:     rd_data_o = 8'h00;
      endcase
    end
  end

  assign int_o     = int_q;
  assign err_cnt_o = cnt_q;
endmodule

// File: rtl/e3_fa_monitor.sv
module e3_fa_monitor
  import e3_fa_pkg::*;
#(
  parameter int FRAME_LEN  = 537,
  parameter int BAD_LIMIT  = 4,
  parameter int LOF_FRAMES = 24,
  parameter int ERR_W      = 16,
  parameter bit ALGO_SEL   = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_vld_i,
  input  logic       frame_start_i,
  input  logic       rd_en_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       oof_o,
  output logic       lof_o
);
  fa_state_e        state;
  logic             realign, check, bad, frame_end, at_start;
  logic             oof_chg, lof_chg, err_inc, cofa;
  logic [4:0]       int_bits;
  logic [ERR_W-1:0] err_cnt;
  logic             err_hi_rd;

  e3_fa_align #(.FRAME_LEN(FRAME_LEN)) u_align (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_i),
    .vld_i       (byte_vld_i),
    .realign_i   (realign),
    .check_o     (check),
    .bad_o       (bad),
    .frame_end_o (frame_end),
    .at_start_o  (at_start)
  );

  e3_fa_state #(.BAD_LIMIT(BAD_LIMIT), .LOF_FRAMES(LOF_FRAMES)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (frame_start_i && byte_vld_i),
    .check_i     (check),
    .bad_i       (bad),
    .frame_end_i (frame_end),
    .state_o     (state),
    .realign_o   (realign),
    .oof_chg_o   (oof_chg),
    .lof_chg_o   (lof_chg),
    .err_o       (err_inc)
  );

  assign cofa  = realign && !at_start;
  assign oof_o = (state != ST_INF);
  assign lof_o = (state == ST_LOF);

  e3_fa_regs #(.ERR_W(ERR_W), .ALGO_SEL(ALGO_SEL)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .oof_i       (oof_o),
    .lof_i       (lof_o),
    .set_oof_i   (oof_chg),
    .set_lof_i   (lof_chg),
    .set_cofa_i  (cofa),
    .err_inc_i   (err_inc),
    .rd_data_o   (rd_data_o),
    .int_o       (int_bits),
    .err_cnt_o   (err_cnt),
    .err_hi_rd_o (err_hi_rd)
  );
endmodule

// File: rtl/e3_fa_monitor_chk.sv
module e3_fa_monitor_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_vld_i,
  input logic             frame_start_i,
  input logic             oof_o,
  input logic             lof_o,
  input logic             bad,
  input logic [4:0]       int_bits,
  input logic [ERR_W-1:0] err_cnt,
  input logic             err_hi_rd
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  AST_LOF_NEEDS_OOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lof_o |-> oof_o); // R7

  AST_OOF_AFTER_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oof_o) |-> $past(bad)); // R3

  AST_REALIGN_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oof_o) |-> $past(frame_start_i && byte_vld_i)); // R8

  AST_REALIGN_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oof_o) |-> (int_bits[3] && int_bits[2])); // R8

  AST_LOF_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_o) |-> int_bits[2]); // R11

  AST_ERR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_cnt) == CNT_MAX && !$past(err_hi_rd)) |-> err_cnt == CNT_MAX); // R5
endmodule

bind e3_fa_monitor e3_fa_monitor_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_vld_i    (byte_vld_i),
  .frame_start_i (frame_start_i),
  .oof_o         (oof_o),
  .lof_o         (lof_o),
  .bad           (bad),
  .int_bits      (int_bits),
  .err_cnt       (err_cnt),
  .err_hi_rd     (err_hi_rd)
);

// File: tb/e3_fa_monitor_test.sv
module e3_fa_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int FLEN       = 8;
  localparam int LOFN       = 6;
  localparam int EW         = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_i = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [2:0] rd_addr_i = 3'd0;
  logic [7:0] rd_data_o;
  logic       oof_o, lof_o;
  logic       pin_chk = 1'b0;

  int checks = 0;
  int errors = 0;
  bit wd_hit = 1'b0;

  typedef struct {
    bit         is_rd;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  e3_fa_monitor #(
    .FRAME_LEN(FLEN), .BAD_LIMIT(4), .LOF_FRAMES(LOFN), .ERR_W(EW), .ALGO_SEL(1'b0)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_vld_i(byte_vld_i),
    .frame_start_i(frame_start_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .oof_o(oof_o), .lof_o(lof_o)
  );

  // monitor: compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      if (rd_en_i || pin_chk) begin
        item_t it;
        logic [7:0] act;
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard %s actual=empty expected=item", "R0");
        end else begin
          it  = sb_q.pop_front();
          act = it.is_rd ? rd_data_o : {6'b0, oof_o, lof_o};
          if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", it.req, act, it.exp);
          end
        end
      end
    end
  end

  task automatic put_byte(input logic [7:0] b, input bit fs);
    byte_i = b; byte_vld_i = 1'b1; frame_start_i = fs;
    @(negedge clk_i);
    byte_vld_i = 1'b0; frame_start_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  task automatic payload(input int n);
    for (int i = 0; i < n; i++) put_byte(8'h00, 1'b0);
  endtask

  task automatic frame(input logic [7:0] f1, input logic [7:0] f2, input bit fs0);
    put_byte(f1, fs0);
    put_byte(f2, 1'b0);
    payload(FLEN - 2);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
    sb_q.push_back('{is_rd: 1'b1, exp: e, req: req});
    rd_addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic pins(input bit eo, input bit el, input string req);
    sb_q.push_back('{is_rd: 1'b0, exp: {6'b0, eo, el}, req: req});
    pin_chk = 1'b1;
    @(negedge clk_i);
    pin_chk = 1'b0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    // R1: reset values
    pins(1, 1, "R1 pins");
    rd(3'd0, 8'h00, "R1 int");
    rd(3'd1, 8'h60, "R1 R12 status");
    rd(3'd2, 8'h00, "R1 err hi");
    rd(3'd3, 8'h00, "R1 err lo");
    // R8: alignment from search
    frame(8'hF6, 8'h28, 1'b1);
    pins(0, 0, "R8 pins low");
    rd(3'd0, 8'h0C, "R8 R11 int both");
    rd(3'd0, 8'h00, "R11 clear on read");
    rd(3'd1, 8'h00, "R12 status inframe");
    rd(3'd5, 8'h00, "R12 unused addr");
    // R2: gaps in byte_vld_i do not shift the frame
    put_byte(8'hF6, 1'b0); idle(); put_byte(8'h28, 1'b0); idle(); idle();
    payload(FLEN - 2);
    frame(8'hF6, 8'h28, 1'b0);
    rd(3'd2, 8'h00, "R2 gap hi");
    rd(3'd3, 8'h00, "R2 gap lo");
    // R3/R4: tolerated errors
    frame(8'hF6, 8'h00, 1'b0);
    frame(8'h00, 8'h28, 1'b0);
    frame(8'h28, 8'hF6, 1'b0);
    frame(8'hF6, 8'h28, 1'b0);
    pins(0, 0, "R3 three bad tolerated");
    frame(8'h00, 8'h00, 1'b0);
    frame(8'hF7, 8'h28, 1'b0);
    frame(8'hF6, 8'h28, 1'b0);
    pins(0, 0, "R3 run restarted");
    rd(3'd2, 8'h00, "R6 hi");
    rd(3'd3, 8'h05, "R4 R6 count five");
    rd(3'd2, 8'h00, "R6 cleared hi");
    rd(3'd3, 8'h00, "R6 cleared lo");
    // R10: frame_start ignored in frame
    put_byte(8'hF6, 1'b0); put_byte(8'h28, 1'b0); put_byte(8'h00, 1'b0);
    put_byte(8'hF6, 1'b1); payload(FLEN - 4);
    frame(8'hF6, 8'h28, 1'b0);
    pins(0, 0, "R10 pins");
    rd(3'd0, 8'h00, "R10 no int");
    rd(3'd2, 8'h00, "R10 hi");
    rd(3'd3, 8'h00, "R10 no error");
    // R3: fourth consecutive bad frame
    frame(8'h00, 8'h00, 1'b0);
    frame(8'hF6, 8'h00, 1'b0);
    frame(8'h00, 8'h28, 1'b0);
    pins(0, 0, "R3 three in row");
    put_byte(8'h12, 1'b0); put_byte(8'h34, 1'b0);
    pins(1, 0, "R3 oof at octet 1");
    payload(FLEN - 2);
    rd(3'd0, 8'h08, "R11 oof bit");
    rd(3'd1, 8'h20, "R12 status oof");
    rd(3'd2, 8'h00, "R4 hi");
    rd(3'd3, 8'h04, "R4 four counted");
    // R7: loss of frame after LOFN boundaries, R4: no counting
    for (int i = 0; i < LOFN - 2; i++) frame(8'h00, 8'h00, 1'b0);
    pins(1, 0, "R7 before limit");
    frame(8'h00, 8'h00, 1'b0);
    pins(1, 1, "R7 lof raised");
    rd(3'd0, 8'h04, "R7 R11 lof bit");
    rd(3'd1, 8'h60, "R12 status lof");
    rd(3'd2, 8'h00, "R4 hi oof");
    rd(3'd3, 8'h00, "R4 none in oof");
    // R9: realign at a different position
    payload(3);
    put_byte(8'hF6, 1'b1); put_byte(8'h28, 1'b0); payload(FLEN - 2);
    pins(0, 0, "R8 realigned");
    rd(3'd0, 8'h1C, "R9 cofa set");
    frame(8'hF6, 8'h28, 1'b0);
    rd(3'd2, 8'h00, "R9 hi");
    rd(3'd3, 8'h00, "R9 new alignment holds");
    // R5: saturation
    for (int i = 0; i < 342; i++) begin
      frame(8'h00, 8'h00, 1'b0);
      frame(8'h00, 8'h00, 1'b0);
      frame(8'h00, 8'h00, 1'b0);
      frame(8'hF6, 8'h28, 1'b0);
    end
    pins(0, 0, "R5 still in frame");
    rd(3'd2, 8'h03, "R5 sat hi");
    rd(3'd3, 8'hFF, "R5 sat lo");
    frame(8'h00, 8'h00, 1'b0);
    rd(3'd2, 8'h00, "R6 restart hi");
    rd(3'd3, 8'h01, "R5 R6 restart lo");
    idle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk_i);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++;
      errors++;
      $display("FAIL watchdog R0 actual=timeout expected=done");
    end
    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule